// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Clock Division

The block is a memory-mapped watchdog timer. A 16-bit live counter counts down on ticks that come from the input clock. The clock first passes through an 8-bit programmable prescaler and then through a fixed divider that software selects. When the live count runs out, the counter reloads from a separate reload register. Depending on two control bits, the block then requests a system reset, raises an interrupt, or does both.

Software keeps the system alive by writing a new value into the live counter before it runs out. To start the timer, software writes the reload register, then the counter, then the control register. Writing the control register also restarts the division chain, so the first tick after a write arrives a known time later. The time to expiry is the count, times the prescaler ratio, times the divider ratio, in input clock cycles.

Register map (word address on `addr`):
- 0, control: [15:8] prescaler ratio minus one; [5] timer enable; [4:3] divider select (0 gives /16, 1 gives /32, 2 gives /64, 3 gives /128); [2] interrupt enable; [0] reset enable. All other bits read as zero.
- 1, reload value.
- 2, live count (a read returns the current value).
- 3, status: [0] interrupt flag. Writing 1 clears it.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control reads 0xFF38, which is prescaler field 0xFF, enable set, divider select 3, interrupt enable clear and reset enable clear. Reload and live count both read 0x8000, and `rstReq` and `irq` are low.
- R2: A write to address 1 sets the reload value and a write to address 2 loads the live count. Both read back the value written.
- R3: While enabled, the live count drops by one every P×D input clocks, where P is the prescaler field plus one. The first drop comes P×D clocks after the control write.
- R4: Divider select codes 0, 1, 2 and 3 give D = 16, 32, 64 and 128.
- R5: Expiry occurs on the tick that finds the live count at 1 or 0. On that tick the live count takes the reload value instead of decrementing, so a count of N expires N×P×D clocks after the control write.
- R6: At expiry with reset enable set, `rstReq` goes high in the following cycle and stays high for exactly 128 clocks. With reset enable clear, expiry leaves `rstReq` low.
- R7: At expiry with interrupt enable set, the flag `irq` is set and stays set. Writing status bit 0 as 1 clears it, and writing it as 0 leaves it set. With interrupt enable clear, expiry leaves `irq` low.
- R8: With enable and reset enable both clear, the live count holds its value and no reset request starts.
- R9: Every write to the control register restarts the prescaler and the divider. The next drop in the count then comes a full P×D clocks after that write.
- R10: Writing the live count before expiry (keep-alive) postpones expiry. The new count runs down on the divider phase that is already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register access select |
| wr | input | 1 | Write when high, read when low |
| addr | input | 2 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational, zero when not selected |
| rstReq | output | 1 | System reset request pulse |
| irq | output | 1 | Sticky expiry interrupt flag |

## Verification
The count-down rate is tried with four settings: prescaler 1 with /16, prescaler 2 with /32, prescaler 1 with /64 and prescaler 1 with /128. Sampling the count one clock before and one clock after the expected tick tells a correct ratio from an off-by-one in either stage. Expiry is tried once with only reset enable set and once with only interrupt enable set. This shows that each output follows its own enable bit, and the reset run also measures the exact pulse width. A control rewrite in the middle of a period shows the chain restarting. A count write before expiry shows the keep-alive: the expected reset does not come at the old time but arrives later, on the divider phase that was already running.

// File: rtl/wdog_pkg.sv
`timescale 1ns/100ps
package wdog_pkg;
  parameter int CNT_W = 16;
  parameter int PRE_W = 8;
  parameter int SEL_W = 2;
  parameter int DATA_W = 16;

  localparam logic [1:0] ADR_CTL = 2'd0;
  localparam logic [1:0] ADR_RLD = 2'd1;
  localparam logic [1:0] ADR_CNT = 2'd2;
  localparam logic [1:0] ADR_STS = 2'd3;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] divSel;
    logic             enable;
    logic             irqEn;
    logic             rstEn;
  } wdCfg_t;

  typedef struct packed {
    logic             loadCnt;
    logic             restart;
    logic [CNT_W-1:0] cntData;
  } wdStrb_t;
endpackage

// File: rtl/wdog_ctrl.sv
`timescale 1ns/100ps
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  liveCount,
  input  logic              expire,
  output wdCfg_t            cfg,
  output logic [CNT_W-1:0]  reloadVal,
  output wdStrb_t           strb,
  output logic              irq
);
  localparam logic [CNT_W-1:0] RESET_COUNT = CNT_W'(1) << (CNT_W - 1);

  logic wrCtl, wrRld, wrCnt, wrSts;
  logic unusedBits;

  assign wrCtl = sel && wr && (addr == ADR_CTL);
  assign wrRld = sel && wr && (addr == ADR_RLD);
  assign wrCnt = sel && wr && (addr == ADR_CNT);
  assign wrSts = sel && wr && (addr == ADR_STS);
  assign unusedBits = ^{wdata[7:6], wdata[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.pre    <= '1;
      cfg.divSel <= '1;
      cfg.enable <= 1'b1;
      cfg.irqEn  <= 1'b0;
      cfg.rstEn  <= 1'b0;
      reloadVal  <= RESET_COUNT;
      irq        <= 1'b0;
    end else begin
      if (wrCtl) begin
        cfg.pre    <= wdata[8 +: PRE_W];
        cfg.enable <= wdata[5];
        cfg.divSel <= wdata[3 +: SEL_W];
        cfg.irqEn  <= wdata[2];
        cfg.rstEn  <= wdata[0];
      end
      if (wrRld) reloadVal <= wdata[CNT_W-1:0];
      if (expire && cfg.irqEn) irq <= 1'b1;
      else if (wrSts && wdata[0]) irq <= 1'b0;
    end
  end

  always_comb begin
    strb.loadCnt = wrCnt;
    strb.restart = wrCtl;
    strb.cntData = wdata[CNT_W-1:0];
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (addr)
        ADR_CTL: begin
          rdata[8 +: PRE_W] = cfg.pre;
          rdata[5]          = cfg.enable;
          rdata[3 +: SEL_W] = cfg.divSel;
          rdata[2]          = cfg.irqEn;
          rdata[0]          = cfg.rstEn;
        end
        ADR_RLD: rdata[CNT_W-1:0] = reloadVal;
        ADR_CNT: rdata[CNT_W-1:0] = liveCount;
        default: rdata[0] = irq;
      endcase
    end
  end
endmodule

// File: rtl/wdog_dp.sv
`timescale 1ns/100ps
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int MIN_DIV_LOG = 4,
  parameter int RST_LEN = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdCfg_t           cfg,
  input  logic [CNT_W-1:0] reloadVal,
  input  wdStrb_t          strb,
  output logic [CNT_W-1:0] liveCount,
  output logic             expire,
  output logic             rstReq
);
  localparam int DIV_W = MIN_DIV_LOG + (1 << SEL_W) - 1;
  localparam int RCNT_W = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] RESET_COUNT = CNT_W'(1) << (CNT_W - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divMask;
  logic [RCNT_W-1:0] rstCnt;
  logic preTick, decTick;
  logic unusedIrqEn;

  assign unusedIrqEn = cfg.irqEn;

  always_comb begin
    divMask = '0;
    for (int i = 0; i < DIV_W; i++)
      if (i < MIN_DIV_LOG + int'(cfg.divSel)) divMask[i] = 1'b1;
  end

  assign preTick = cfg.enable && (preCnt == cfg.pre);
  assign decTick = preTick && ((divCnt & divMask) == divMask);
  assign expire  = decTick && (liveCount <= CNT_W'(1));
  assign rstReq  = (rstCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (strb.restart) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (cfg.enable) begin
      preCnt <= preTick ? '0 : preCnt + 1'b1;
      if (preTick) divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveCount <= RESET_COUNT;
    else if (strb.loadCnt) liveCount <= strb.cntData;
    else if (expire) liveCount <= reloadVal;
    else if (decTick) liveCount <= liveCount - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstCnt <= '0;
    else if (expire && cfg.rstEn) rstCnt <= RCNT_W'(RST_LEN);
    else if (rstCnt != '0) rstCnt <= rstCnt - 1'b1;
  end
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/100ps
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int MIN_DIV_LOG = 4,
  parameter int RST_LEN = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rstReq,
  output logic              irq
);
  wdCfg_t           cfg;
  wdStrb_t          strb;
  logic [CNT_W-1:0] liveCount;
  logic [CNT_W-1:0] reloadVal;
  logic             expire;

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .liveCount(liveCount),
    .expire(expire), .cfg(cfg), .reloadVal(reloadVal),
    .strb(strb), .irq(irq)
  );

  wdog_dp #(.MIN_DIV_LOG(MIN_DIV_LOG), .RST_LEN(RST_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .reloadVal(reloadVal),
    .strb(strb), .liveCount(liveCount), .expire(expire),
    .rstReq(rstReq)
  );
endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/100ps
module wdog_chk
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sel,
  input logic              wr,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              rstReq,
  input logic              irq,
  input logic [CNT_W-1:0]  liveCount,
  input logic [CNT_W-1:0]  reloadVal,
  input logic              expire,
  input logic              enable,
  input logic              rstEn,
  input logic              irqEn
);
  logic cntWr, stsClr;
  assign cntWr  = sel && wr && (addr == ADR_CNT);
  assign stsClr = sel && wr && (addr == ADR_STS) && wdata[0];

  // R5: expiry loads the reload value unless a count write wins
  a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !cntWr) |=> (liveCount == $past(reloadVal)));

  // R6: a reset request starts only from an expiry with reset enable
  a_r6_rst_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> ($past(expire) && $past(rstEn)));

  // R7: interrupt flag rises only from an expiry with interrupt enable
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(expire) && $past(irqEn)));

  // R7: flag holds until cleared by a write of one
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !stsClr) |=> irq);

  // R8: a stopped timer holds its count
  a_r8_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !cntWr) |=> $stable(liveCount));
endmodule

bind wdog_timer wdog_chk chk (
  .clk(clk), .rstN(rstN), .sel(sel), .wr(wr), .addr(addr),
  .wdata(wdata), .rstReq(rstReq), .irq(irq), .liveCount(liveCount),
  .reloadVal(reloadVal), .expire(expire), .enable(cfg.enable),
  .rstEn(cfg.rstEn), .irqEn(cfg.irqEn)
);

// File: tb/wdog_timer_test.sv
`timescale 1ns/100ps
module wdog_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        rstReq;
  logic        irq;
  int nChecks = 0;
  int nFails = 0;

  wdog_timer uut (
    .clk(clk), .rstN(rstN), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rstReq(rstReq), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [15:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [15:0] rld, input logic [15:0] cnt,
                       input logic [15:0] ctl);
    busWrite(2'd0, 16'h0000);
    busWrite(2'd1, rld);
    busWrite(2'd2, cnt);
    busWrite(2'd0, ctl);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    busRead(2'd0, v); check("R1 control", v, 16'hFF38);
    busRead(2'd1, v); check("R1 reload", v, 16'h8000);
    busRead(2'd2, v); check("R1 count", v, 16'h8000);
    check("R1 rstReq", rstReq, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    busWrite(2'd0, 16'h0000);
    busWrite(2'd1, 16'h1234);
    busWrite(2'd2, 16'h0042);
    busRead(2'd1, v); check("R2 reload", v, 16'h1234);
    busRead(2'd2, v); check("R2 count", v, 16'h0042);
    wait_n(300);
    busRead(2'd2, v); check("R8 count held", v, 16'h0042);
    check("R8 no reset", rstReq, 0);
  endtask

  task automatic t_rst_expiry;
    logic [15:0] v;
    start(16'd100, 16'd3, 16'h0021);
    wait_n(15);
    busRead(2'd2, v); check("R3 before tick", v, 3);
    wait_n(1);
    busRead(2'd2, v); check("R3 first tick", v, 2);
    wait_n(31);
    busRead(2'd2, v); check("R5 before expiry", v, 1);
    check("R6 low before expiry", rstReq, 0);
    wait_n(1);
    busRead(2'd2, v); check("R5 reloaded", v, 100);
    check("R6 high at expiry", rstReq, 1);
    check("R7 irq off when disabled", irq, 0);
    wait_n(127);
    check("R6 high last cycle", rstReq, 1);
    wait_n(1);
    check("R6 low after 128", rstReq, 0);
    busWrite(2'd0, 16'h0000);
  endtask

  task automatic t_rate(input string req, input logic [15:0] ctl, input int period);
    logic [15:0] v;
    start(16'd50, 16'd5, ctl);
    wait_n(period - 1);
    busRead(2'd2, v); check({req, " before tick"}, v, 5);
    wait_n(1);
    busRead(2'd2, v); check({req, " at tick"}, v, 4);
    busWrite(2'd0, 16'h0000);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    start(16'd7, 16'd1, 16'h003C);
    wait_n(127);
    check("R7 irq before expiry", irq, 0);
    wait_n(1);
    check("R7 irq set", irq, 1);
    check("R6 no reset when disabled", rstReq, 0);
    busRead(2'd2, v); check("R5 reload 7", v, 7);
    wait_n(200);
    check("R7 irq sticky", irq, 1);
    busWrite(2'd3, 16'h0000);
    check("R7 write 0 keeps", irq, 1);
    busWrite(2'd3, 16'h0001);
    check("R7 write 1 clears", irq, 0);
    busWrite(2'd0, 16'h0000);
  endtask

  task automatic t_restart;
    logic [15:0] v;
    start(16'd50, 16'd10, 16'h0020);
    wait_n(10);
    busWrite(2'd0, 16'h0020);
    wait_n(15);
    busRead(2'd2, v); check("R9 no tick yet", v, 10);
    wait_n(1);
    busRead(2'd2, v); check("R9 tick after restart", v, 9);
    busWrite(2'd0, 16'h0000);
  endtask

  task automatic t_keepalive;
    logic [15:0] v;
    start(16'd100, 16'd3, 16'h0021);
    wait_n(40);
    busWrite(2'd2, 16'd3);
    wait_n(7);
    check("R10 no reset at old time", rstReq, 0);
    busRead(2'd2, v); check("R10 count", v, 2);
    wait_n(32);
    check("R10 reset later", rstReq, 1);
    busWrite(2'd0, 16'h0000);
    wait_n(200);
    check("R8 no new reset", rstReq, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    wait_n(3);
    rstN = 1'b1;
    wait_n(1);
    t_reset();
    t_regs();
    t_rst_expiry();
    t_rate("R4 div32 pre2", 16'h0128, 64);
    t_rate("R4 div64", 16'h0030, 64);
    t_rate("R4 div128", 16'h0038, 128);
    t_rate("R3 div16", 16'h0020, 16);
    t_irq();
    t_restart();
    t_keepalive();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule